// File: doc/BRIEF.md
# Prefixed Opcode Addressing-Mode Decoder

This block sits at the front of an 8-bit accumulator CPU's instruction path and receives opcode bytes one at a time with a valid strobe. For a small set of instructions it names the operation, the addressing mode, how many operand bytes follow the opcode and how many cycles the instruction takes in total. The two nibbles of an ordinary opcode are decoded separately: the low nibble picks the operation and the high nibble picks the mode.

One byte value, 0x9E, is a page prefix. It produces no decode of its own. Instead it arms a pending state, and the next byte is read against a second mode map in which two high-nibble codes select stack-pointer-relative addressing. A prefixed byte that fits neither of those codes is flagged illegal, and the pending state is dropped. The decode result is registered and is presented for exactly one cycle after the byte that completes the instruction. Operand fetch, address arithmetic and execution are handled by later stages.

Top module: `pfx_opdec`

## Requirements
- R1: After reset is asserted, `dec_valid` and `pfx_pending` are both 0.
- R2: For a byte without a prefix, the high nibble sets `dec_mode`: 0xA gives immediate (code 2), 0xB gives direct (3), 0xC gives extended (4), 0xD gives 16-bit-offset indexed (5), 0xE gives 8-bit-offset indexed (6) and 0xF gives no-offset indexed (7).
- R3: The low nibble sets `dec_op`: 0x0 gives subtract (code 1), 0x2 gives subtract with carry (2), 0x7 gives store A (3) and 0xF gives store X (4).
- R4: `dec_cycles` and `dec_nbytes` depend on the mode. Immediate is 2 cycles and 1 byte. Direct is 3 and 1. Extended is 4 and 2. 16-bit indexed is 4 and 2. 8-bit indexed is 3 and 1. No-offset indexed is 2 and 0. Stack 8-bit is 4 and 1. Stack 16-bit is 5 and 2.
- R5: Store A (0xA7) and store X (0xAF) in immediate mode are illegal.
- R6: The fixed opcodes each decode with mode inherent (code 1), 0 operand bytes and their own cycle count. They are 0x99 set carry (op 6, 1 cycle), 0x9B set interrupt mask (op 7, 2), 0x8E stop (op 8, 1), 0x83 software interrupt (op 9, 9), 0x84 A to CCR (op 10, 2), 0x97 A to X (op 11, 1) and 0x85 CCR to A (op 12, 1). Opcode 0x35 is store H:X (op 5) in direct mode (3), with 1 operand byte and 4 cycles.
- R7: A strobed 0x9E while no prefix is pending sets `pfx_pending` to 1 on the next cycle and produces no `dec_valid`.
- R8: While a prefix is pending, a high nibble of 0xE gives stack 8-bit mode (code 8) and 0xD gives stack 16-bit mode (code 9), with the low-nibble operation of R3.
- R9: While a prefix is pending, any byte that does not map under R8 is decoded as illegal, including a second 0x9E. Every strobed byte clears `pfx_pending`.
- R10: An illegal decode drives `dec_illegal`=1 with `dec_op`, `dec_mode`, `dec_nbytes` and `dec_cycles` all 0. Any unprefixed byte that is not listed in R2, R3 or R6 is illegal.
- R11: `dec_valid` is high for exactly one cycle, the one after the final byte of an instruction is strobed. On cycles without a strobe, `pfx_pending` holds its value and `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Opcode byte strobe |
| in_byte | input | 8 | Opcode byte |
| dec_valid | output | 1 | Decode result valid |
| dec_illegal | output | 1 | Byte did not decode |
| dec_op | output | 4 | Operation code |
| dec_mode | output | 4 | Addressing mode code |
| dec_nbytes | output | 2 | Operand bytes that follow |
| dec_cycles | output | 4 | Total instruction cycles |
| pfx_pending | output | 1 | Prefix received, awaiting next byte |

## Verification
The bench aims at the prefix boundaries. It sends a prefix followed by a second prefix, which a design that re-arms would swallow silently. It sends a prefix followed by an ordinary indexed opcode, which a design that ignores the pending state would decode as a legal indexed access. It checks idle gaps between the prefix and its follower, which a design that clears the pending state on any cycle would lose. It also covers immediate-mode stores, which a nibble-only decoder would accept, and the fixed inherent bytes whose high nibbles fall outside the mode map, where a mistaken cycle count would show up directly. Random bytes, with prefixes inserted in between, are compared against an independent byte-level model.

// File: rtl/pfx_opdec_pkg.sv
package pfx_opdec_pkg;

  localparam int BYTE_W  = 8;
  localparam int NIB_W   = 4;
  localparam int CODE_W  = 4;
  localparam int NBYTE_W = 2;
  localparam int CYC_W   = 4;

  typedef enum logic [CODE_W-1:0] {
    OPK_NONE = 4'd0,
    OPK_SUB  = 4'd1,
    OPK_SBC  = 4'd2,
    OPK_STA  = 4'd3,
    OPK_STX  = 4'd4,
    OPK_STHX = 4'd5,
    OPK_SEC  = 4'd6,
    OPK_SEI  = 4'd7,
    OPK_STOP = 4'd8,
    OPK_SWI  = 4'd9,
    OPK_TAP  = 4'd10,
    OPK_TAX  = 4'd11,
    OPK_TPA  = 4'd12
  } opkind_e;

  typedef enum logic [CODE_W-1:0] {
    AM_NONE = 4'd0,
    AM_INH  = 4'd1,
    AM_IMM  = 4'd2,
    AM_DIR  = 4'd3,
    AM_EXT  = 4'd4,
    AM_IX2  = 4'd5,
    AM_IX1  = 4'd6,
    AM_IX   = 4'd7,
    AM_SP1  = 4'd8,
    AM_SP2  = 4'd9
  } amode_e;

  typedef struct packed {
    logic               illegal;
    opkind_e            op;
    amode_e             mode;
    logic [NBYTE_W-1:0] nbytes;
    logic [CYC_W-1:0]   ncyc;
  } dec_t;

  localparam dec_t DEC_BLANK_ILLEGAL = '{illegal: 1'b1, op: OPK_NONE,
                                         mode: AM_NONE, nbytes: '0, ncyc: '0};

  // Operation named by the low nibble of a mode-map opcode.
  function automatic opkind_e op_of_low(input logic [NIB_W-1:0] lo);
    case (lo)
      4'h0:    return OPK_SUB;
      4'h2:    return OPK_SBC;
      4'h7:    return OPK_STA;
      4'hF:    return OPK_STX;
      default: return OPK_NONE;
    endcase
  endfunction

  // Mode from the high nibble when no prefix is pending.
  function automatic amode_e mode_plain(input logic [NIB_W-1:0] hi);
    case (hi)
      4'hA:    return AM_IMM;
      4'hB:    return AM_DIR;
      4'hC:    return AM_EXT;
      4'hD:    return AM_IX2;
      4'hE:    return AM_IX1;
      4'hF:    return AM_IX;
      default: return AM_NONE;
    endcase
  endfunction

  // Mode from the high nibble after a prefix.
  function automatic amode_e mode_paged(input logic [NIB_W-1:0] hi);
    case (hi)
      4'hE:    return AM_SP1;
      4'hD:    return AM_SP2;
      default: return AM_NONE;
    endcase
  endfunction

  function automatic logic [CYC_W-1:0] cycles_of_mode(input amode_e m);
    case (m)
      AM_IMM:  return 4'd2;
      AM_DIR:  return 4'd3;
      AM_EXT:  return 4'd4;
      AM_IX2:  return 4'd4;
      AM_IX1:  return 4'd3;
      AM_IX:   return 4'd2;
      AM_SP1:  return 4'd4;
      AM_SP2:  return 4'd5;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [NBYTE_W-1:0] nbytes_of_mode(input amode_e m);
    case (m)
      AM_IMM, AM_DIR, AM_IX1, AM_SP1: return 2'd1;
      AM_EXT, AM_IX2, AM_SP2:         return 2'd2;
      default:                        return 2'd0;
    endcase
  endfunction

  // Stores write memory, so an immediate operand has no meaning for them.
  function automatic logic op_mode_legal(input opkind_e op, input amode_e m);
    if (op == OPK_NONE || m == AM_NONE) return 1'b0;
    if ((op == OPK_STA || op == OPK_STX) && m == AM_IMM) return 1'b0;
    return 1'b1;
  endfunction

  // Whole-byte opcodes outside the nibble map.
  function automatic dec_t fixed_lookup(input logic [BYTE_W-1:0] b);
    dec_t d;
    d = DEC_BLANK_ILLEGAL;
    case (b)
      8'h99: d = '{1'b0, OPK_SEC,  AM_INH, 2'd0, 4'd1};
      8'h9B: d = '{1'b0, OPK_SEI,  AM_INH, 2'd0, 4'd2};
      8'h8E: d = '{1'b0, OPK_STOP, AM_INH, 2'd0, 4'd1};
      8'h83: d = '{1'b0, OPK_SWI,  AM_INH, 2'd0, 4'd9};
      8'h84: d = '{1'b0, OPK_TAP,  AM_INH, 2'd0, 4'd2};
      8'h97: d = '{1'b0, OPK_TAX,  AM_INH, 2'd0, 4'd1};
      8'h85: d = '{1'b0, OPK_TPA,  AM_INH, 2'd0, 4'd1};
      8'h35: d = '{1'b0, OPK_STHX, AM_DIR, 2'd1, 4'd4};
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/opdec_prefix_trk.sv
module opdec_prefix_trk
  import pfx_opdec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PFX_CODE = 8'h9E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              pending_o,
  output logic              arm_o,
  output logic              consume_o
);

  logic pending_q;

  // A prefix arms only from the idle state; a second one is consumed as a follower.
  assign arm_o     = in_valid && !pending_q && (in_byte == PFX_CODE);
  assign consume_o = in_valid && pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pending_q <= 1'b0;
    else if (arm_o)     pending_q <= 1'b1;
    else if (consume_o) pending_q <= 1'b0;
  end

  assign pending_o = pending_q;

  AST_PFX_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    arm_o |=> pending_q) else $error("prefix did not arm"); // R7

  AST_PFX_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    consume_o |=> !pending_q) else $error("prefix survived follower"); // R9

  AST_PFX_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pending_q)) else $error("pending moved while idle"); // R11

endmodule

// File: rtl/opdec_core.sv
module opdec_core
  import pfx_opdec_pkg::*;
(
  input  logic              paged_i,
  input  logic [BYTE_W-1:0] byte_i,
  output dec_t              dec_o,
  output logic              map_hit_o
);

  logic [NIB_W-1:0] hi, lo;
  opkind_e          op_n;
  amode_e           mode_n;
  logic             nib_ok;
  dec_t             fixed_d;

  assign hi = byte_i[BYTE_W-1 -: NIB_W];
  assign lo = byte_i[NIB_W-1:0];

  always_comb begin
    op_n    = op_of_low(lo);
    mode_n  = paged_i ? mode_paged(hi) : mode_plain(hi);
    nib_ok  = op_mode_legal(op_n, mode_n);
    fixed_d = fixed_lookup(byte_i);
  end

  assign map_hit_o = nib_ok;

  always_comb begin
    if (nib_ok) begin
      dec_o = '{illegal: 1'b0, op: op_n, mode: mode_n,
                nbytes: nbytes_of_mode(mode_n), ncyc: cycles_of_mode(mode_n)};
    end else if (!paged_i) begin
      dec_o = fixed_d;
    end else begin
      dec_o = DEC_BLANK_ILLEGAL;
    end
  end

  always_comb begin
    if (!nib_ok && !dec_o.illegal)
      assert (dec_o.mode == AM_INH || dec_o.op == OPK_STHX)
        else $error("fixed decode outside its set"); // R6
  end

endmodule

// File: rtl/opdec_out_reg.sv
module opdec_out_reg
  import pfx_opdec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  dec_t dec_i,
  output logic valid_o,
  output dec_t dec_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      dec_o   <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) dec_o <= dec_i;
    end
  end

endmodule

// File: rtl/pfx_opdec.sv
module pfx_opdec
  import pfx_opdec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PFX_CODE = 8'h9E
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [BYTE_W-1:0]    in_byte,
  output logic                 dec_valid,
  output logic                 dec_illegal,
  output logic [CODE_W-1:0]    dec_op,
  output logic [CODE_W-1:0]    dec_mode,
  output logic [NBYTE_W-1:0]   dec_nbytes,
  output logic [CYC_W-1:0]     dec_cycles,
  output logic                 pfx_pending
);

  logic pending_w, arm_w, consume_w, map_hit_w, final_byte_w;
  dec_t comb_dec, held_dec;

  opdec_prefix_trk #(.PFX_CODE(PFX_CODE)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .pending_o (pending_w),
    .arm_o     (arm_w),
    .consume_o (consume_w)
  );

  opdec_core u_core (
    .paged_i   (pending_w),
    .byte_i    (in_byte),
    .dec_o     (comb_dec),
    .map_hit_o (map_hit_w)
  );

  // Every strobed byte except an arming prefix ends an instruction.
  assign final_byte_w = in_valid && !arm_w;

  opdec_out_reg u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (final_byte_w),
    .dec_i   (comb_dec),
    .valid_o (dec_valid),
    .dec_o   (held_dec)
  );

  assign dec_illegal = held_dec.illegal;
  assign dec_op      = held_dec.op;
  assign dec_mode    = held_dec.mode;
  assign dec_nbytes  = held_dec.nbytes;
  assign dec_cycles  = held_dec.ncyc;
  assign pfx_pending = pending_w;

  AST_VALID_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid) && !$past(arm_w)) else $error("spurious valid"); // R11

  AST_ARM_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    arm_w |=> !dec_valid) else $error("prefix produced a decode"); // R7

  AST_ILLEGAL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_illegal |-> dec_op == 4'd0 && dec_mode == 4'd0
      && dec_nbytes == 2'd0 && dec_cycles == 4'd0) else $error("illegal not blank"); // R10

  AST_SP_NEEDS_PFX: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && (dec_mode == AM_SP1 || dec_mode == AM_SP2) |-> $past(pending_w))
    else $error("stack mode without prefix"); // R8

  AST_STORE_NOT_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && (dec_op == OPK_STA || dec_op == OPK_STX) |-> dec_mode != AM_IMM)
    else $error("store decoded as immediate"); // R5

  AST_PAGED_MAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    consume_w && !map_hit_w |=> dec_valid && dec_illegal)
    else $error("bad follower not flagged"); // R9

endmodule

// File: tb/tb_pfx_opdec.sv
module tb_pfx_opdec;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_byte;
  logic       dec_valid, dec_illegal, pfx_pending;
  logic [3:0] dec_op, dec_mode, dec_cycles;
  logic [1:0] dec_nbytes;

  int n_chk = 0;
  int n_bad = 0;
  logic model_pend = 1'b0;

  always #5 clk = ~clk;

  pfx_opdec dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .dec_valid(dec_valid), .dec_illegal(dec_illegal), .dec_op(dec_op),
    .dec_mode(dec_mode), .dec_nbytes(dec_nbytes), .dec_cycles(dec_cycles),
    .pfx_pending(pfx_pending)
  );

  // Expected {illegal, op, mode, nbytes, cycles}, written per whole byte.
  function automatic logic [14:0] expect_dec(input logic pf, input logic [7:0] b);
    int op, md, cy, nb;
    op = 0; md = 0;
    if (b[3:0] == 4'h0) op = 1;
    else if (b[3:0] == 4'h2) op = 2;
    else if (b[3:0] == 4'h7) op = 3;
    else if (b[3:0] == 4'hF) op = 4;
    if (pf) md = (b[7:4] == 4'hE) ? 8 : (b[7:4] == 4'hD) ? 9 : 0;
    else if (b[7:4] >= 4'hA) md = int'(b[7:4]) - 8;
    if (op != 0 && md != 0 && !(md == 2 && op >= 3)) begin
      case (md)
        2: begin cy = 2; nb = 1; end
        3: begin cy = 3; nb = 1; end
        4: begin cy = 4; nb = 2; end
        5: begin cy = 4; nb = 2; end
        6: begin cy = 3; nb = 1; end
        7: begin cy = 2; nb = 0; end
        8: begin cy = 4; nb = 1; end
        default: begin cy = 5; nb = 2; end
      endcase
      return {1'b0, 4'(op), 4'(md), 2'(nb), 4'(cy)};
    end
    if (!pf) begin
      case (b)
        8'h99: return {1'b0, 4'd6,  4'd1, 2'd0, 4'd1};
        8'h9B: return {1'b0, 4'd7,  4'd1, 2'd0, 4'd2};
        8'h8E: return {1'b0, 4'd8,  4'd1, 2'd0, 4'd1};
        8'h83: return {1'b0, 4'd9,  4'd1, 2'd0, 4'd9};
        8'h84: return {1'b0, 4'd10, 4'd1, 2'd0, 4'd2};
        8'h97: return {1'b0, 4'd11, 4'd1, 2'd0, 4'd1};
        8'h85: return {1'b0, 4'd12, 4'd1, 2'd0, 4'd1};
        8'h35: return {1'b0, 4'd5,  4'd3, 2'd1, 4'd4};
        default: ;
      endcase
    end
    return {1'b1, 14'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one byte, then check at the following falling edge.
  task automatic send(input logic [7:0] b, input string req);
    logic [14:0] e;
    @(negedge clk);
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
    if (!model_pend && b == 8'h9E) begin
      check({req, " R7 pending"}, 32'(pfx_pending), 32'd1);
      check({req, " R7 no valid"}, 32'(dec_valid), 32'd0);
      model_pend = 1'b1;
    end else begin
      e = expect_dec(model_pend, b);
      check({req, " valid"}, 32'(dec_valid), 32'd1);
      check({req, " fields"},
            32'({dec_illegal, dec_op, dec_mode, dec_nbytes, dec_cycles}), 32'(e));
      check({req, " R9 pending cleared"}, 32'(pfx_pending), 32'd0);
      model_pend = 1'b0;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 valid at reset", 32'(dec_valid), 32'd0);
    check("R1 pending at reset", 32'(pfx_pending), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle valid", 32'(dec_valid), 32'd0);

    // R2 R3 R4 every mode with subtract, plus other operations
    send(8'hA0, "R2 imm"); send(8'hB2, "R2 dir"); send(8'hC7, "R3 ext");
    send(8'hDF, "R4 ix2"); send(8'hE2, "R4 ix1"); send(8'hF7, "R4 ix");
    // R5 stores at immediate
    send(8'hA7, "R5 sta imm"); send(8'hAF, "R5 stx imm"); send(8'hA2, "R5 sbc imm ok");
    // R6 fixed opcodes
    send(8'h99, "R6"); send(8'h9B, "R6"); send(8'h8E, "R6"); send(8'h83, "R6");
    send(8'h84, "R6"); send(8'h97, "R6"); send(8'h85, "R6"); send(8'h35, "R6 sthx");
    // R8 stack modes
    send(8'h9E, "R7"); send(8'hE0, "R8 sp1");
    send(8'h9E, "R7"); send(8'hDF, "R8 sp2");
    // R9 bad followers
    send(8'h9E, "R7"); send(8'h9E, "R9 double prefix");
    send(8'h9E, "R7"); send(8'hF0, "R9 ix after prefix");
    send(8'h9E, "R7"); send(8'h99, "R9 inherent after prefix");
    // R10 unlisted
    send(8'h00, "R10"); send(8'hA3, "R10"); send(8'h9F, "R10");
    // R11 idle gap holds pending
    send(8'h9E, "R7");
    repeat (4) @(negedge clk);
    check("R11 pending held", 32'(pfx_pending), 32'd1);
    check("R11 no valid while idle", 32'(dec_valid), 32'd0);
    send(8'hE7, "R8 after gap");
    @(negedge clk);
    check("R11 single-cycle valid", 32'(dec_valid), 32'd0);

    // Random mix with injected prefixes
    r = 8'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 4) == 0) send(8'h9E, "R7 rnd");
      r = 8'($urandom);
      if (($urandom % 3) == 0) r[7:4] = 4'hA + 4'($urandom % 6);
      send(r, "R2 R8 R10 rnd");
      if (($urandom % 8) == 0) repeat (2) @(negedge clk);
    end

    // Reset mid-prefix
    send(8'h9E, "R7");
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears prefix", 32'(pfx_pending), 32'd0);
    rst_n = 1'b1; model_pend = 1'b0;
    send(8'hE0, "R1 plain after reset");
    summary();
  end

endmodule